// File: doc/BRIEF.md
# Raster and Event Interrupt Controller

This block merges four display and audio events into a single active-high interrupt request for the host CPU. The four events are the start of vertical sync, the raster reaching a programmed line, a sprite collision, and an audio sample buffer that has run low. Video timing, collision detection and the sample buffer live elsewhere. They hand this block one-cycle pulses for vertical sync and collision, a level for the low buffer, and the live 9-bit scanline number.

The host reaches the block through a small byte-wide register port with a 2-bit address. Writes are strobed and reads are combinational.

- Address 0 is the enable register. It also carries bit 8 of the compare line on writes and bit 8 of the live scanline on reads.
- Address 1 is the status register.
- Address 2 has two roles. Writing it sets the low byte of the compare line. Reading it returns the low byte of the live scanline.
- Address 3 reads as zero.

Sticky status bits latch the pulse-type events until the host clears them. The buffer-low bit simply mirrors its input.

Top module: `raster_irq_ctrl`

## Requirements
- R1: While reset is low and right after it is released, the enable bits, sticky status bits and compare line are all zero, and `irq` is low.
- R2: Writing address 0 stores bits 3:0 as the source enables: bit 0 vertical sync, bit 1 line match, bit 2 collision, bit 3 buffer low. Reading address 0 returns those enables in bits 3:0 and bit 8 of the live scanline in bit 6. Bits 7, 5 and 4 read as zero, so the bit 7 compare value cannot be read back.
- R3: The 9-bit compare line takes bit 8 from bit 7 of a write to address 0 and bits 7:0 from a write to address 2. Reading address 2 returns bits 7:0 of the live scanline. Reading address 3 returns zero.
- R4: A `vsync_pulse` sets status bit 0 on the next clock edge. The bit then stays set until the host writes address 1 with bit 0 set. Writes to address 1 with bit 0 clear leave it unchanged.
- R5: Status bit 1 is set on the edge that follows a cycle in which two things hold: the scanline input differs from its value one cycle earlier, and it equals the compare line. It is set once per such change. Writing a compare value equal to a scanline that is not moving sets nothing. The bit clears when address 1 is written with bit 1 set.
- R6: A `coll_pulse` sets status bit 2 on the next edge. The bit clears when address 1 is written with bit 2 set.
- R7: Status bit 3 reads the current `aud_low` level. Writes cannot clear it. Status bits 7:4 read as zero.
- R8: `irq` is high exactly when at least one status bit 0 to 3 is set and its source enable is set. Masked sources still update their status bits.
- R9: When a source event and a clear of the same sticky bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized before this block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| vsync_pulse | input | 1 | One-cycle vertical sync event |
| coll_pulse | input | 1 | One-cycle sprite collision event |
| aud_low | input | 1 | Audio buffer low-water level |
| scanline | input | 9 | Current raster line |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives the scanline through values around 300, so the match depends on the ninth bit. A controller that drops bit 7 of address 0 would then never fire, or would fire at line 44. It holds the scanline still for several cycles at the compare value and also programs a compare that equals a line that is not moving. A level comparator instead of a change detector would fire repeatedly in the first case or spuriously in the second. It issues a clear together with a new event, and a clear that leaves some bits untouched, which exposes designs where clear has priority or where a write wipes the whole status byte. It also writes a clear to the buffer-low bit, and a design that made it sticky would hold `irq` after the level drops.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned LINE_W     = 9;
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned NUM_STICKY = 3;

  // Source bit positions, shared by enable and status registers
  localparam int unsigned SRC_VSYNC = 0;
  localparam int unsigned SRC_LINE  = 1;
  localparam int unsigned SRC_COLL  = 2;
  localparam int unsigned SRC_AUD   = 3;

  // Enable register extra fields
  localparam int unsigned EN_SCAN_HI = 6;
  localparam int unsigned EN_CMP_HI  = 7;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_LINE   = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import raster_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_line_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_q,
  output logic [LINE_W-1:0]  cmp_q
);
  logic [NUM_SRC-1:0] en_d;
  logic [LINE_W-1:0]  cmp_d;
  logic               cmp_ce;

  always_comb begin
    en_d   = en_q;
    cmp_d  = cmp_q;
    cmp_ce = wr_en_i | wr_line_i;
    if (wr_en_i) begin
      en_d             = wdata_i[NUM_SRC-1:0];
      cmp_d[LINE_W-1]  = wdata_i[EN_CMP_HI];
    end
    if (wr_line_i) begin
      cmp_d[DATA_W-1:0] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_en_i) en_q  <= en_d;
      if (cmp_ce)  cmp_q <= cmp_d;
    end
  end
endmodule

// File: rtl/irq_line_match.sv
module irq_line_match
  import raster_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] scanline_i,
  input  logic [LINE_W-1:0] cmp_i,
  output logic              hit_o
);
  logic [LINE_W-1:0] prev_q;
  logic              vld_q;
  logic              moved;

  assign moved = vld_q && (scanline_i != prev_q);
  assign hit_o = moved && (scanline_i == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= scanline_i;
      vld_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status
  import raster_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STICKY-1:0] set_i,
  input  logic [NUM_STICKY-1:0] clr_i,
  output logic [NUM_STICKY-1:0] sts_q
);
  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_bit
    logic ce;
    logic d;
    always_comb begin
      ce = set_i[g] | clr_i[g];
      d  = set_i[g];   // set has priority over clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sts_q[g] <= 1'b0;
      else if (ce) sts_q[g] <= d;
    end
  end
endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import raster_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              vsync_pulse,
  input  logic              coll_pulse,
  input  logic              aud_low,
  input  logic [LINE_W-1:0] scanline,
  output logic              irq
);
  logic [NUM_SRC-1:0]    en_q;
  logic [LINE_W-1:0]     cmp_q;
  logic [NUM_STICKY-1:0] sts_q;
  logic [NUM_STICKY-1:0] sts_set;
  logic [NUM_STICKY-1:0] sts_clr;
  logic [NUM_SRC-1:0]    pend;
  logic                  line_hit;
  logic                  wr_enable;
  logic                  wr_status;
  logic                  wr_line;

  always_comb begin
    wr_enable = bus_wr && (bus_addr == RA_ENABLE);
    wr_status = bus_wr && (bus_addr == RA_STATUS);
    wr_line   = bus_wr && (bus_addr == RA_LINE);
  end

  irq_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_enable),
    .wr_line_i (wr_line),
    .wdata_i   (bus_wdata),
    .en_q      (en_q),
    .cmp_q     (cmp_q)
  );

  irq_line_match u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .scanline_i (scanline),
    .cmp_i      (cmp_q),
    .hit_o      (line_hit)
  );

  always_comb begin
    sts_set            = '0;
    sts_set[SRC_VSYNC] = vsync_pulse;
    sts_set[SRC_LINE]  = line_hit;
    sts_set[SRC_COLL]  = coll_pulse;
    sts_clr            = wr_status ? bus_wdata[NUM_STICKY-1:0] : '0;
  end

  irq_sticky_status u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sts_set),
    .clr_i (sts_clr),
    .sts_q (sts_q)
  );

  always_comb begin
    pend                   = '0;
    pend[NUM_STICKY-1:0]   = sts_q;
    pend[SRC_AUD]          = aud_low;
    irq                    = |(pend & en_q);
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_ENABLE: begin
        bus_rdata[NUM_SRC-1:0] = en_q;
        bus_rdata[EN_SCAN_HI]  = scanline[LINE_W-1];
      end
      RA_STATUS: bus_rdata[NUM_SRC-1:0] = pend;
      RA_LINE:   bus_rdata = scanline[DATA_W-1:0];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
  import raster_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  vsync_pulse,
  input logic                  coll_pulse,
  input logic                  aud_low,
  input logic [LINE_W-1:0]     scanline,
  input logic                  irq,
  input logic [NUM_SRC-1:0]    en_q,
  input logic [LINE_W-1:0]     cmp_q,
  input logic [NUM_STICKY-1:0] sts_q,
  input logic                  line_hit
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (irq == 1'b0)
        else $error("R1: irq high during reset");
    end
  end

  a_r4_vsync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_pulse |=> sts_q[SRC_VSYNC]);

  a_r4_vsync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[SRC_VSYNC] && !(bus_wr && bus_addr == RA_STATUS && bus_wdata[SRC_VSYNC]))
      |=> sts_q[SRC_VSYNC]);

  a_r5_hit_equals_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |-> (scanline == cmp_q));

  a_r5_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> sts_q[SRC_LINE]);

  a_r6_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |=> sts_q[SRC_COLL]);

  a_r7_aud_live: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_STATUS) |-> (bus_rdata[SRC_AUD] == aud_low));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind raster_irq_ctrl raster_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .vsync_pulse (vsync_pulse),
  .coll_pulse  (coll_pulse),
  .aud_low     (aud_low),
  .scanline    (scanline),
  .irq         (irq),
  .en_q        (en_q),
  .cmp_q       (cmp_q),
  .sts_q       (sts_q),
  .line_hit    (line_hit)
);

// File: tb/raster_irq_ctrl_tb.sv
module raster_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       vsync_pulse, coll_pulse, aud_low;
  logic [8:0] scanline;
  logic       irq;

  // pending drive values, applied at the falling edge
  logic       d_rst, d_wr, d_vs, d_co, d_aud;
  logic [1:0] d_addr;
  logic [7:0] d_wdata;
  logic [8:0] d_scan;

  // reference model state
  int m_en, m_cmp, m_sts, m_prev;
  bit m_vld;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync_pulse(vsync_pulse),
    .coll_pulse(coll_pulse), .aud_low(aud_low), .scanline(scanline), .irq(irq)
  );

  function automatic int exp_rd();
    case (d_addr)
      2'd0: return (m_en & 15) | (((d_scan >> 8) & 1) << 6);
      2'd1: return (m_sts & 7) | (int'(d_aud) << 3);
      2'd2: return d_scan & 255;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_irq();
    int p = (m_sts & 7) | (int'(d_aud) << 3);
    return (p & m_en) != 0;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    rst_n = d_rst; bus_wr = d_wr; bus_addr = d_addr; bus_wdata = d_wdata;
    vsync_pulse = d_vs; coll_pulse = d_co; aud_low = d_aud; scanline = d_scan;
    #1;
    check("rdata", int'(bus_rdata), exp_rd());
    check("irq", int'(irq), int'(exp_irq()));
    @(posedge clk);
    if (!d_rst) begin
      m_en = 0; m_cmp = 0; m_sts = 0; m_prev = 0; m_vld = 0;
    end else begin
      int setm = 0, clrm = 0;
      if (d_vs) setm |= 1;
      if (m_vld && int'(d_scan) != m_prev && int'(d_scan) == m_cmp) setm |= 2;
      if (d_co) setm |= 4;
      if (d_wr && d_addr == 2'd1) clrm = d_wdata & 7;
      m_sts = ((m_sts & ~clrm) | setm) & 7;
      if (d_wr && d_addr == 2'd0) begin
        m_en  = d_wdata & 15;
        m_cmp = (m_cmp & 255) | (((d_wdata >> 7) & 1) << 8);
      end
      if (d_wr && d_addr == 2'd2) m_cmp = (m_cmp & 256) | d_wdata;
      m_prev = d_scan; m_vld = 1;
    end
    d_wr = 0; d_vs = 0; d_co = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    d_wr = 1; d_addr = a; d_wdata = v; cyc();
  endtask

  task automatic rd(input logic [1:0] a, input int n);
    d_addr = a;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    d_rst = 0; d_wr = 0; d_vs = 0; d_co = 0; d_aud = 0;
    d_addr = 0; d_wdata = 0; d_scan = 0;
    m_en = 0; m_cmp = 0; m_sts = 0; m_prev = 0; m_vld = 0;
    // R1: reset state, all addresses
    tag = "R1";
    rd(2'd0, 2); rd(2'd1, 1); d_rst = 1; rd(2'd1, 2); rd(2'd0, 1);
    // R2: enable register fields, scanline bit 8 in bit 6, bit 7 unreadable
    tag = "R2";
    d_scan = 9'h1A5;
    wr(2'd0, 8'hFF); rd(2'd0, 2);
    d_scan = 9'h0A5; rd(2'd0, 1);
    wr(2'd0, 8'h00); rd(2'd0, 1);
    // R3: compare line halves, live scanline low byte, reserved address
    tag = "R3";
    d_scan = 9'h077; wr(2'd2, 8'h34); rd(2'd2, 2); rd(2'd3, 1);
    // R4: vsync sticky and write-one-to-clear
    tag = "R4";
    wr(2'd0, 8'h01); d_addr = 2'd1; d_vs = 1; cyc(); rd(2'd1, 2);
    wr(2'd1, 8'h06); rd(2'd1, 1);
    wr(2'd1, 8'h01); rd(2'd1, 2);
    // R5: line match at line 300 (bit 8 set), once per change
    tag = "R5";
    wr(2'd0, 8'h82); wr(2'd2, 8'h2C);
    d_addr = 2'd1;
    for (int s = 296; s <= 303; s++) begin
      d_scan = s[8:0]; cyc();
      if (s == 300) rd(2'd1, 3);   // held at the compare value
    end
    d_scan = 9'd44; rd(2'd1, 2);  // low byte alone must not match
    wr(2'd1, 8'h02); rd(2'd1, 1);
    d_scan = 9'd50; rd(2'd1, 2);
    wr(2'd0, 8'h02); wr(2'd2, 8'd50); rd(2'd1, 3);  // static equal line
    d_scan = 9'd51; rd(2'd1, 1); d_scan = 9'd50; rd(2'd1, 2);
    wr(2'd1, 8'h02); rd(2'd1, 1);
    // R6: collision sticky
    tag = "R6";
    wr(2'd0, 8'h04); d_addr = 2'd1; d_co = 1; cyc(); rd(2'd1, 2);
    wr(2'd1, 8'h04); rd(2'd1, 2);
    // R7: buffer-low is live and not clearable
    tag = "R7";
    wr(2'd0, 8'h08); d_aud = 1; rd(2'd1, 2);
    wr(2'd1, 8'hFF); rd(2'd1, 2);
    d_aud = 0; rd(2'd1, 2);
    // R8: masked sources latch without irq, enabling raises it
    tag = "R8";
    wr(2'd0, 8'h00); d_addr = 2'd1; d_vs = 1; d_co = 1; d_aud = 1; cyc();
    rd(2'd1, 2); wr(2'd0, 8'h04); rd(2'd1, 1); wr(2'd0, 8'h01); rd(2'd1, 1);
    wr(2'd1, 8'h07); d_aud = 0; rd(2'd1, 1); wr(2'd0, 8'h0F); rd(2'd1, 1);
    // R9: event and clear in the same cycle keeps the bit set
    tag = "R9";
    d_vs = 1; wr(2'd1, 8'h01); rd(2'd1, 2);
    d_co = 1; wr(2'd1, 8'h05); rd(2'd1, 2);
    wr(2'd1, 8'h07); rd(2'd1, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule